// File: doc/BRIEF.md
# Searchable Scoreboard FIFO

This block is the queue between the decode and execute stages of a small in-order pipeline. Each slot holds one decoded instruction: a two-bit kind, a destination register name and two operand values. Execute reads the oldest slot at the head. It pops the slot when the instruction retires normally. It flushes the whole queue when a branch-if-zero at the head is taken.

Decode needs to stall on read-after-write hazards. For that it uses a set of combinational lookup ports. Each port takes a register name and reports whether any live slot will write that register. Only add and load slots can produce a match.

Operations in one cycle have a fixed order. The head is read first. Pop or flush comes next. The lookups see the queue after that pop or flush. The push comes last and is not seen by the lookups in the cycle it happens.

Top module: `sb_fifo`

## Requirements
- R1: After reset the queue is empty: `head_valid_o` is 0, `enq_ready_o` is 1, and every lookup port reports no match.
- R2: Slots leave in the order they were pushed. The head outputs show the kind, destination and both operand values of the oldest slot.
- R3: `enq_ready_o` is 0 when all DEPTH slots are occupied and neither `deq_i` nor `clear_i` is high. A push offered while not ready is dropped.
- R4: `deq_i` while the queue is empty has no effect. The queue stays empty, and a later push becomes the head.
- R5: A lookup port reports a match when some live slot has kind add (0) or load (2) and its destination equals the port's register name.
- R6: A slot of kind branch-if-zero (1) or store (3) never causes a match, whatever its destination field holds.
- R7: The NUM_PORTS lookup ports are independent. Port k compares against bits [k*5 +: 5] of `srch_reg_i` and drives bit k of `srch_hit_o`.
- R8: A slot that is being popped in the current cycle is not seen by that cycle's lookups.
- R9: In a cycle with `clear_i` high, every lookup reports no match. A slot pushed in the current cycle is not seen by that cycle's lookups.
- R10: `clear_i` empties the queue in one cycle. If a push is accepted in the same cycle, the queue then holds only the pushed slot.
- R11: `enq_ready_o` is 1 whenever `deq_i` or `clear_i` is high. A pop and a push on a full queue therefore both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Push request |
| enq_kind_i | input | 2 | Kind of the pushed slot: 0 add, 1 branch-if-zero, 2 load, 3 store |
| enq_dst_i | input | 5 | Destination register name of the pushed slot |
| enq_a_i | input | 32 | First operand value |
| enq_b_i | input | 32 | Second operand value |
| enq_ready_o | output | 1 | A push is accepted this cycle |
| head_valid_o | output | 1 | The queue is not empty |
| head_kind_o | output | 2 | Kind of the oldest slot |
| head_dst_o | output | 5 | Destination register name of the oldest slot |
| head_a_o | output | 32 | First operand of the oldest slot |
| head_b_o | output | 32 | Second operand of the oldest slot |
| deq_i | input | 1 | Pop the oldest slot |
| clear_i | input | 1 | Flush all slots |
| srch_reg_i | input | NUM_PORTS*5 | Register names to look up, one 5-bit field per port |
| srch_hit_o | output | NUM_PORTS | Match result for each port |

## Verification
The bench builds the block with its defaults: DEPTH of 2 and two lookup ports. With a depth of 2, the full condition and the wrap of the read and write pointers both come within two or three pushes. That lets one short sequence cover a pop and a push together on a full queue, and a flush together with a push on a full queue. Two ports allow each lookup to be paired with a different slot kind in the same cycle, so a non-writing kind and a writing kind are told apart side by side.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_BZ  = 2'd1,
    K_LD  = 2'd2,
    K_ST  = 2'd3
  } op_kind_e;

  typedef struct packed {
    op_kind_e             kind;
    logic [REG_W-1:0]     dst;
    logic [DATA_W-1:0]    val_a;
    logic [DATA_W-1:0]    val_b;
  } slot_t;

  function automatic logic writes_reg(op_kind_e k);
    return (k == K_ADD) || (k == K_LD);
  endfunction
endpackage

// File: rtl/sb_fifo_store.sv
module sb_fifo_store
  import sb_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  slot_t            wdata_i,
  output slot_t            slot_o [DEPTH],
  output logic [DEPTH-1:0] vld_o,
  output logic [PTR_W-1:0] rd_ptr_o
);
  slot_t            slots_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PTR_W-1:0] rd_q, wr_q, wr_idx;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_idx = flush_i ? '0 : wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      if (push_i) begin
        vld_q[0] <= 1'b1;
        wr_q     <= ptr_inc('0);
      end
    end else begin
      if (pop_i) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= ptr_inc(rd_q);
      end
      // a push into the slot just popped must win
      if (push_i) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= ptr_inc(wr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slots_q[wr_idx] <= wdata_i;
  end

  assign slot_o   = slots_q;
  assign vld_o    = vld_q;
  assign rd_ptr_o = rd_q;
endmodule

// File: rtl/sb_match_port.sv
module sb_match_port
  import sb_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  slot_t            slot_i [DEPTH],
  input  logic [DEPTH-1:0] live_i,
  input  logic [REG_W-1:0] key_i,
  output logic             hit_o
);
  logic [DEPTH-1:0] match;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    assign match[s] = live_i[s] && writes_reg(slot_i[s].kind) &&
                      (slot_i[s].dst == key_i);
  end

  assign hit_o = |match;
endmodule

// File: rtl/sb_fifo.sv
module sb_fifo
  import sb_pkg::*;
#(
  parameter int unsigned DEPTH     = 2,
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enq_valid_i,
  input  logic [1:0]                 enq_kind_i,
  input  logic [4:0]                 enq_dst_i,
  input  logic [31:0]                enq_a_i,
  input  logic [31:0]                enq_b_i,
  output logic                       enq_ready_o,
  output logic                       head_valid_o,
  output logic [1:0]                 head_kind_o,
  output logic [4:0]                 head_dst_o,
  output logic [31:0]                head_a_o,
  output logic [31:0]                head_b_o,
  input  logic                       deq_i,
  input  logic                       clear_i,
  input  logic [NUM_PORTS*5-1:0]     srch_reg_i,
  output logic [NUM_PORTS-1:0]       srch_hit_o
);
  slot_t            slots [DEPTH];
  slot_t            wdata, head;
  logic [DEPTH-1:0] vld, live, pop_mask;
  logic [PTR_W-1:0] rd_ptr;
  logic             not_empty, full, deq_eff, push, pop;

  assign not_empty = |vld;
  assign full      = &vld;
  assign deq_eff   = deq_i && not_empty;
  assign pop       = deq_eff && !clear_i;
  // full implies not empty, so a raised deq_i always frees a slot
  assign enq_ready_o = clear_i || deq_i || !full;
  assign push        = enq_valid_i && enq_ready_o;

  assign wdata = '{kind: op_kind_e'(enq_kind_i), dst: enq_dst_i,
                   val_a: enq_a_i, val_b: enq_b_i};

  sb_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .flush_i  (clear_i),
    .wdata_i  (wdata),
    .slot_o   (slots),
    .vld_o    (vld),
    .rd_ptr_o (rd_ptr)
  );

  // lookups see the state after pop/flush, before push
  always_comb begin
    pop_mask         = '0;
    pop_mask[rd_ptr] = deq_eff;
  end
  assign live = clear_i ? '0 : (vld & ~pop_mask);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sb_match_port #(.DEPTH(DEPTH)) u_port (
      .slot_i (slots),
      .live_i (live),
      .key_i  (srch_reg_i[p*REG_W +: REG_W]),
      .hit_o  (srch_hit_o[p])
    );
  end

  assign head         = slots[rd_ptr];
  assign head_valid_o = not_empty;
  assign head_kind_o  = head.kind;
  assign head_dst_o   = head.dst;
  assign head_a_o     = head.val_a;
  assign head_b_o     = head.val_b;
endmodule

// File: rtl/sb_fifo_chk.sv
module sb_fifo_chk #(
  parameter int unsigned DEPTH     = 2,
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   enq_valid_i,
  input logic [4:0]             enq_dst_i,
  input logic                   enq_ready_o,
  input logic                   head_valid_o,
  input logic [4:0]             head_dst_o,
  input logic                   deq_i,
  input logic                   clear_i,
  input logic [NUM_PORTS-1:0]   srch_hit_o
);
  int unsigned occ;
  logic        acc;
  assign acc = enq_valid_i && enq_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      occ <= 0;
    else if (clear_i) occ <= acc ? 1 : 0;
    else              occ <= occ + (acc ? 1 : 0) - ((deq_i && occ != 0) ? 1 : 0);
  end

  p_occ_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_o == (occ != 0));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ >= DEPTH && !deq_i && !clear_i) |-> !enq_ready_o);
  p_ready_on_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_i || clear_i) |-> enq_ready_o);
  p_empty_no_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_o |-> (srch_hit_o == '0));
  p_clear_no_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (srch_hit_o == '0));
  p_clear_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !enq_valid_i) |=> !head_valid_o);
  p_clear_enq_head_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && enq_valid_i) |=> (head_valid_o && head_dst_o == $past(enq_dst_i)));
  p_empty_deq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!head_valid_o && deq_i && !enq_valid_i) |=> !head_valid_o);
endmodule

bind sb_fifo sb_fifo_chk #(.DEPTH(DEPTH), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enq_valid_i  (enq_valid_i),
  .enq_dst_i    (enq_dst_i),
  .enq_ready_o  (enq_ready_o),
  .head_valid_o (head_valid_o),
  .head_dst_o   (head_dst_o),
  .deq_i        (deq_i),
  .clear_i      (clear_i),
  .srch_hit_o   (srch_hit_o)
);

// File: tb/sim_sb_fifo.sv
`timescale 1ns/1ps
module sim_sb_fifo;
  localparam logic [1:0] ADD = 2'd0, BZ = 2'd1, LD = 2'd2, ST = 2'd3;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        enq_valid_i, deq_i, clear_i;
  logic [1:0]  enq_kind_i;
  logic [4:0]  enq_dst_i;
  logic [31:0] enq_a_i, enq_b_i;
  logic [9:0]  srch_reg_i;
  logic        enq_ready_o, head_valid_o;
  logic [1:0]  head_kind_o, srch_hit_o;
  logic [4:0]  head_dst_o;
  logic [31:0] head_a_o, head_b_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  sb_fifo u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    enq_valid_i = 0; enq_kind_i = 0; enq_dst_i = 0; enq_a_i = 0; enq_b_i = 0;
    deq_i = 0; clear_i = 0; srch_reg_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i); #2; idle();
  endtask

  task automatic push(logic [1:0] k, logic [4:0] d, logic [31:0] a, logic [31:0] b);
    enq_valid_i = 1; enq_kind_i = k; enq_dst_i = d; enq_a_i = a; enq_b_i = b;
  endtask

  task automatic keys(logic [4:0] k0, logic [4:0] k1);
    srch_reg_i = {k1, k0};
  endtask

  task automatic t_reset();
    #1;
    chk("R1 head_valid", head_valid_o, 0);
    chk("R1 ready", enq_ready_o, 1);
    chk("R1 hits", srch_hit_o, 0);
  endtask

  task automatic t_order_full();
    push(ADD, 3, 10, 11); #1 chk("R3 ready empty", enq_ready_o, 1); step();
    push(LD, 7, 20, 21); step();
    #1 chk("R3 ready full", enq_ready_o, 0);
    push(ST, 9, 30, 31); step();
    #1 chk("R2 head dst", head_dst_o, 3);
    chk("R2 head kind", head_kind_o, ADD);
    chk("R2 head a", head_a_o, 10);
    chk("R2 head b", head_b_o, 11);
    deq_i = 1; step();
    #1 chk("R2 second dst", head_dst_o, 7);
    chk("R2 second kind", head_kind_o, LD);
    chk("R2 second a", head_a_o, 20);
    deq_i = 1; step();
    #1 chk("R3 dropped push", head_valid_o, 0);
  endtask

  task automatic t_search();
    keys(20, 21); push(ADD, 20, 1, 2);
    #1 chk("R9 push unseen", srch_hit_o, 2'b00); step();
    push(BZ, 21, 0, 5); step();
    keys(20, 21); #1 chk("R5 R6 add vs branch", srch_hit_o, 2'b01);
    keys(21, 20); #1 chk("R7 ports swapped", srch_hit_o, 2'b10);
    keys(20, 20); deq_i = 1; #1 chk("R8 popped unseen", srch_hit_o, 2'b00); step();
    keys(21, 21); #1 chk("R6 branch only", srch_hit_o, 2'b00);
    deq_i = 1; step();
    push(LD, 12, 3, 4); step();
    push(ST, 13, 5, 6); step();
    keys(12, 13); #1 chk("R5 R6 load vs store", srch_hit_o, 2'b01);
    keys(13, 12); #1 chk("R7 load on port1", srch_hit_o, 2'b10);
    keys(12, 14); #1 chk("R5 no false match", srch_hit_o, 2'b01);
    deq_i = 1; step(); deq_i = 1; step();
    #1 chk("R2 drained", head_valid_o, 0);
  endtask

  task automatic t_clear();
    push(ADD, 17, 0, 0); step();
    push(LD, 18, 0, 0); step();
    keys(17, 18); clear_i = 1;
    #1 chk("R9 clear hits", srch_hit_o, 2'b00);
    chk("R11 ready on clear", enq_ready_o, 1);
    step();
    #1 chk("R10 emptied", head_valid_o, 0);
    chk("R10 ready after", enq_ready_o, 1);
    keys(17, 18); #1 chk("R10 no stale hit", srch_hit_o, 2'b00);
    push(ADD, 5, 0, 0); step();
    push(LD, 6, 0, 0); step();
    clear_i = 1; push(ADD, 25, 7, 8); step();
    #1 chk("R10 clear+push valid", head_valid_o, 1);
    chk("R10 clear+push dst", head_dst_o, 25);
    chk("R10 clear+push a", head_a_o, 7);
    keys(25, 5); #1 chk("R10 only new slot", srch_hit_o, 2'b01);
    deq_i = 1; step();
    #1 chk("R10 single slot", head_valid_o, 0);
  endtask

  task automatic t_deq_full();
    push(ADD, 1, 0, 0); step();
    push(ADD, 2, 0, 0); step();
    deq_i = 1; push(LD, 3, 0, 0);
    #1 chk("R11 ready pop+push", enq_ready_o, 1); step();
    #1 chk("R11 head after", head_dst_o, 2);
    chk("R11 still full", enq_ready_o, 0);
    deq_i = 1; step();
    #1 chk("R11 wrapped slot", head_dst_o, 3);
    deq_i = 1; step();
    #1 chk("R11 drained", head_valid_o, 0);
  endtask

  task automatic t_empty_deq();
    deq_i = 1; step();
    #1 chk("R4 still empty", head_valid_o, 0);
    chk("R4 ready", enq_ready_o, 1);
    push(ADD, 4, 9, 9); step();
    #1 chk("R4 push becomes head", head_dst_o, 4);
    chk("R4 head valid", head_valid_o, 1);
    deq_i = 1; step();
    #1 chk("R4 empty again", head_valid_o, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    t_reset();
    t_order_full();
    t_search();
    t_clear();
    t_deq_full();
    t_empty_deq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule